// File: doc/BRIEF.md
# Byte ALU with Nibble Carry

This block is the arithmetic and logic stage of a small accumulator machine. Each operation takes two bytes: the working register value `w_in` and a second operand `a_in`, which is either a file register or an immediate. It also takes the present carry, nibble-carry and zero flags. One cycle after `op_valid`, registered outputs give the result byte, a high product byte, and the three flag values. With them come per-flag write enables and write enables for the result and the high byte. The surrounding core uses these to decide what to store.

Subtraction always computes the operand minus W. The carry is a "no borrow" indication, and subtract-with-carry takes the inverted carry flag as its borrow. The nibble carry is the carry, or no-borrow, across the bit 3 to bit 4 boundary of the same operation. Multiply returns a 16-bit product: its low byte goes out on the result and its high byte on a separate output.

Top module: `alu8_dc`

## Requirements
- R1: While `rst` is high at a clock edge, all registered outputs become zero.
- R2: The outputs for an operation appear at the first clock edge after `op_valid` is sampled high, and `valid_q` is `op_valid` delayed by one cycle. A cycle with `op_valid` low leaves every other output unchanged.
- R3: The operation codes are ADD=0, ADDC=1, SUB=2, SUBC=3, CMP=4, AND=5, OR=6, XOR=7, NOT=8, INC=9, DEC=10, RL=11, RR=12, SWAP=13, MULU=14 and MULS=15. ADD gives w+a and ADDC gives w+a+c_in. For both, carry is the carry out of bit 7, nibble carry is the carry out of bit 3, and zero is set when the result is 0. All three flags are enabled.
- R4: SUB gives a-w, and SUBC gives a-w-(1-c_in). Carry is set when the subtraction did not borrow. Nibble carry is set when the low-nibble subtraction, including the same borrow-in, did not borrow. Zero follows the result, and all three flags are enabled.
- R5: CMP gives the same flag values and enables as SUB and puts a-w on `res_q`, but `res_we_q` is 0.
- R6: AND, OR, XOR (with w), NOT a, INC (a+1) and DEC (a-1) enable only the zero flag, which is set when the result is 0.
- R7: RL gives {a[6:0],c_in} and carry a[7]. RR gives {c_in,a[7:1]} and carry a[0]. Only the carry flag is enabled.
- R8: SWAP gives {a[3:0],a[7:4]} and enables no flag.
- R9: MULU and MULS give the 16-bit product of w and a, with zero extension and with sign extension respectively. The low byte goes on `res_q` and the high byte on `hi_q`, and no flag is enabled. For all other operations `hi_q` is 0.
- R10: `fwe_q` bit 0 is the carry enable, bit 1 the nibble-carry enable and bit 2 the zero enable. Each flag output whose enable is 0 equals the matching flag input of that operation.
- R11: `res_we_q` is 1 for every operation except CMP. `hi_we_q` is 1 only for MULU and MULS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code (see R3) |
| w_in | input | 8 | Working register value |
| a_in | input | 8 | File register or immediate operand |
| c_in | input | 1 | Present carry flag |
| dc_in | input | 1 | Present nibble-carry flag |
| z_in | input | 1 | Present zero flag |
| res_q | output | 8 | Result byte (low product byte for multiply) |
| hi_q | output | 8 | High product byte |
| c_q | output | 1 | Carry flag value |
| dc_q | output | 1 | Nibble-carry flag value |
| z_q | output | 1 | Zero flag value |
| fwe_q | output | 3 | Flag write enables {zero, nibble carry, carry} |
| res_we_q | output | 1 | Result write enable |
| hi_we_q | output | 1 | High byte write enable |
| valid_q | output | 1 | Outputs belong to an operation |

## Verification
The bench targets the points where the flag rules are easy to get wrong.

- **Nibble carry at 0x0F+0x01.** A design that took the nibble carry from bit 4, or from the full sum, would report it wrongly here.
- **Subtraction edges.** Equal operands and a borrowing subtraction expose a carry with inverted sense or operands in swapped order. SUBC with a clear carry catches a borrow-in taken without inversion.
- **Sign-extension products.** 0x80×0x80, 0xFF×0x02 and 0xFF×0xFF under both multiply forms would show a missing or misplaced sign extension in the high byte.
- **Rotates and disabled flags.** Rotates with the carry set, and random traffic with random incoming flags, show any flag that is written when it should pass through.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUB  = 4'd2,  OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,  OP_AND  = 4'd5,  OP_OR   = 4'd6,  OP_XOR  = 4'd7,
    OP_NOT  = 4'd8,  OP_INC  = 4'd9,  OP_DEC  = 4'd10, OP_RL   = 4'd11,
    OP_RR   = 4'd12, OP_SWAP = 4'd13, OP_MULU = 4'd14, OP_MULS = 4'd15
  } alu_op_e;

  localparam int FL_C  = 0;
  localparam int FL_DC = 1;
  localparam int FL_Z  = 2;
  localparam int FL_N  = 3;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          hcout
);
  localparam int HW = DW / 2;
  localparam int UW = DW - HW;

  logic [HW:0] lo;
  logic [UW:0] hi;

  always_comb begin
    lo = {1'b0, x[HW-1:0]} + {1'b0, y[HW-1:0]} + {{HW{1'b0}}, cin};
    hi = {1'b0, x[DW-1:HW]} + {1'b0, y[DW-1:HW]} + {{UW{1'b0}}, lo[HW]};
    sum   = {hi[UW-1:0], lo[HW-1:0]};
    cout  = hi[UW];
    hcout = lo[HW];
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] w,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout
);
  localparam int HW = DW / 2;

  logic [DW-1:0] swapped;

  // nibble exchange, one bit at a time
  for (genvar i = 0; i < DW; i++) begin : g_swap
    if (i < HW) begin : g_lo
      assign swapped[i] = a[i + DW - HW];
    end else begin : g_hi
      assign swapped[i] = a[i - HW];
    end
  end

  always_comb begin
    res  = '0;
    cout = cin;
    unique case (op)
      OP_AND:  res = a & w;
      OP_OR:   res = a | w;
      OP_XOR:  res = a ^ w;
      OP_NOT:  res = ~a;
      OP_INC:  res = a + {{(DW-1){1'b0}}, 1'b1};
      OP_DEC:  res = a - {{(DW-1){1'b0}}, 1'b1};
      OP_RL: begin
        res  = {a[DW-2:0], cin};
        cout = a[DW-1];
      end
      OP_RR: begin
        res  = {cin, a[DW-1:1]};
        cout = a[0];
      end
      OP_SWAP: res = swapped;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   w,
  input  logic            sgn,
  output logic [2*DW-1:0] prod
);
  localparam int EW = DW + 1;

  logic signed [EW-1:0]   ax;
  logic signed [EW-1:0]   wx;
  logic signed [2*EW-1:0] full;

  always_comb begin
    ax   = {sgn & a[DW-1], a};
    wx   = {sgn & w[DW-1], w};
    full = ax * wx;
    prod = full[2*DW-1:0];
  end
endmodule

// File: rtl/alu8_dc.sv
module alu8_dc
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [3:0]    op,
  input  logic [DW-1:0] w_in,
  input  logic [DW-1:0] a_in,
  input  logic          c_in,
  input  logic          dc_in,
  input  logic          z_in,
  output logic [DW-1:0] res_q,
  output logic [DW-1:0] hi_q,
  output logic          c_q,
  output logic          dc_q,
  output logic          z_q,
  output logic [2:0]    fwe_q,
  output logic          res_we_q,
  output logic          hi_we_q,
  output logic          valid_q
);
  alu_op_e       opc;
  logic          is_sub;
  logic [DW-1:0] ax, ay;
  logic          acin;
  logic [DW-1:0] asum;
  logic          acout, ahc;
  logic [DW-1:0] lres;
  logic          lcout;
  logic [2*DW-1:0] prod;

  logic [DW-1:0]   res_d, hi_d;
  logic [FL_N-1:0] fl_new, fwe_d, fl_d;
  logic            res_we_d, hi_we_d;

  assign opc = alu_op_e'(op);

  // shared adder: subtraction is a + ~w + carry-in
  always_comb begin
    is_sub = (opc == OP_SUB) || (opc == OP_SUBC) || (opc == OP_CMP);
    ax     = a_in;
    ay     = is_sub ? ~w_in : w_in;
    unique case (opc)
      OP_ADDC, OP_SUBC: acin = c_in;
      OP_SUB, OP_CMP:   acin = 1'b1;
      default:          acin = 1'b0;
    endcase
  end

  alu8_addsub #(.DW(DW)) u_addsub (
    .x(ax), .y(ay), .cin(acin), .sum(asum), .cout(acout), .hcout(ahc)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .op(opc), .a(a_in), .w(w_in), .cin(c_in), .res(lres), .cout(lcout)
  );

  alu8_mul #(.DW(DW)) u_mul (
    .a(a_in), .w(w_in), .sgn(opc == OP_MULS), .prod(prod)
  );

  always_comb begin
    res_d    = lres;
    hi_d     = '0;
    fwe_d    = '0;
    fl_new   = '0;
    res_we_d = 1'b1;
    hi_we_d  = 1'b0;
    unique case (opc)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        res_d        = asum;
        fl_new[FL_C] = acout;
        fl_new[FL_DC]= ahc;
        fwe_d        = '1;
        res_we_d     = (opc != OP_CMP);
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_INC, OP_DEC: begin
        fwe_d[FL_Z] = 1'b1;
      end
      OP_RL, OP_RR: begin
        fl_new[FL_C] = lcout;
        fwe_d[FL_C]  = 1'b1;
      end
      OP_MULU, OP_MULS: begin
        res_d   = prod[DW-1:0];
        hi_d    = prod[2*DW-1:DW];
        hi_we_d = 1'b1;
      end
      default: ;
    endcase
    fl_new[FL_Z] = (res_d == '0);
    fl_d[FL_C]   = fwe_d[FL_C]  ? fl_new[FL_C]  : c_in;
    fl_d[FL_DC]  = fwe_d[FL_DC] ? fl_new[FL_DC] : dc_in;
    fl_d[FL_Z]   = fwe_d[FL_Z]  ? fl_new[FL_Z]  : z_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q    <= '0;
      hi_q     <= '0;
      c_q      <= 1'b0;
      dc_q     <= 1'b0;
      z_q      <= 1'b0;
      fwe_q    <= '0;
      res_we_q <= 1'b0;
      hi_we_q  <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= op_valid;
      if (op_valid) begin
        res_q    <= res_d;
        hi_q     <= hi_d;
        c_q      <= fl_d[FL_C];
        dc_q     <= fl_d[FL_DC];
        z_q      <= fl_d[FL_Z];
        fwe_q    <= fwe_d;
        res_we_q <= res_we_d;
        hi_we_q  <= hi_we_d;
      end
    end
  end
endmodule

// File: rtl/alu8_dc_chk.sv
module alu8_dc_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic [3:0]    op,
  input logic [DW-1:0] a_in,
  input logic          c_in,
  input logic          dc_in,
  input logic          z_in,
  input logic [DW-1:0] res_q,
  input logic [DW-1:0] hi_q,
  input logic          c_q,
  input logic          dc_q,
  input logic          z_q,
  input logic [2:0]    fwe_q,
  input logic          res_we_q,
  input logic          hi_we_q,
  input logic          valid_q
);
  localparam int HW = DW / 2;

  p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (valid_q == $past(op_valid)));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(res_q) && $stable(fwe_q));

  p_cmp_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 4'd4) |=> !res_we_q && fwe_q == 3'b111);

  p_rotate_carry_only_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op == 4'd11 || op == 4'd12)) |=> fwe_q == 3'b001);

  p_swap_nibbles_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 4'd13) |=>
      fwe_q == 3'b000 && res_q == {$past(a_in[HW-1:0]), $past(a_in[DW-1:HW])});

  p_mul_no_flags_r9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op >= 4'd14) |=> hi_we_q && fwe_q == 3'b000);

  p_hi_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op < 4'd14) |=> !hi_we_q && hi_q == '0);

  p_flag_pass_r10: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (fwe_q[0] || c_q == $past(c_in)) &&
                 (fwe_q[1] || dc_q == $past(dc_in)) &&
                 (fwe_q[2] || z_q == $past(z_in)));
endmodule

bind alu8_dc alu8_dc_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .a_in(a_in),
  .c_in(c_in), .dc_in(dc_in), .z_in(z_in), .res_q(res_q), .hi_q(hi_q),
  .c_q(c_q), .dc_q(dc_q), .z_q(z_q), .fwe_q(fwe_q), .res_we_q(res_we_q),
  .hi_we_q(hi_we_q), .valid_q(valid_q)
);

// File: tb/alu8_dc_test.sv
module alu8_dc_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] w_in = '0, a_in = '0;
  logic       c_in = 1'b0, dc_in = 1'b0, z_in = 1'b0;
  logic [7:0] res_q, hi_q;
  logic       c_q, dc_q, z_q, res_we_q, hi_we_q, valid_q;
  logic [2:0] fwe_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  alu8_dc uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .w_in(w_in),
    .a_in(a_in), .c_in(c_in), .dc_in(dc_in), .z_in(z_in), .res_q(res_q),
    .hi_q(hi_q), .c_q(c_q), .dc_q(dc_q), .z_q(z_q), .fwe_q(fwe_q),
    .res_we_q(res_we_q), .hi_we_q(hi_we_q), .valid_q(valid_q)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int o);
    if (o <= 1) return "R3";
    if (o <= 3) return "R4";
    if (o == 4) return "R5";
    if (o <= 10) return "R6";
    if (o <= 12) return "R7";
    if (o == 13) return "R8";
    return "R9";
  endfunction

  // reference model written from the requirement text
  function automatic void model(input int o, input int a, input int w,
      input int c, input int dc, input int z,
      output int r, output int hi, output int fc, output int fdc,
      output int fz, output int en, output int rwe, output int hwe);
    int s, b, sa, sw, p;
    hi = 0; rwe = 1; hwe = 0; en = 0; fc = c; fdc = dc; fz = z; r = 0;
    case (o)
      0, 1: begin
        b = (o == 1) ? c : 0;
        s = a + w + b;
        r = s & 255; fc = (s > 255); fdc = ((a % 16) + (w % 16) + b) > 15;
        fz = (r == 0); en = 7;
      end
      2, 3, 4: begin
        b = (o == 3) ? (1 - c) : 0;
        r = (a - w - b) & 255; fc = (a >= w + b);
        fdc = ((a % 16) >= (w % 16) + b); fz = (r == 0); en = 7;
        rwe = (o != 4);
      end
      5, 6, 7, 8, 9, 10: begin
        case (o)
          5: r = a & w;
          6: r = a | w;
          7: r = a ^ w;
          8: r = 255 - a;
          9: r = (a + 1) % 256;
          default: r = (a + 255) % 256;
        endcase
        fz = (r == 0); en = 4;
      end
      11: begin r = ((a * 2) % 256) + c; fc = a / 128; en = 1; end
      12: begin r = (a / 2) + c * 128; fc = a % 2; en = 1; end
      13: r = (a % 16) * 16 + a / 16;
      default: begin
        sa = (o == 15 && a > 127) ? a - 256 : a;
        sw = (o == 15 && w > 127) ? w - 256 : w;
        p = (sa * sw) & 65535;
        r = p & 255; hi = p / 256; hwe = 1;
      end
    endcase
  endfunction

  task automatic run(input int o, input int a, input int w,
                     input int c, input int dc, input int z);
    int r, hi, fc, fdc, fz, en, rwe, hwe;
    string t;
    @(negedge clk);
    op_valid = 1'b1; op = 4'(o); a_in = 8'(a); w_in = 8'(w);
    c_in = c[0]; dc_in = dc[0]; z_in = z[0];
    @(negedge clk);
    op_valid = 1'b0;
    model(o, a, w, c, dc, z, r, hi, fc, fdc, fz, en, rwe, hwe);
    t = tag_of(o);
    chk({t, " res"}, res_q, r);
    chk({t, " hi"}, hi_q, hi);
    chk({t, " c"}, c_q, fc);
    chk({t, " dc"}, dc_q, fdc);
    chk({t, " z"}, z_q, fz);
    chk("R10 fwe", fwe_q, en);
    chk("R11 we", {res_we_q, hi_we_q}, rwe * 2 + hwe);
    chk("R2 valid", valid_q, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 res", res_q, 0);
    chk("R1 flags", {c_q, dc_q, z_q, fwe_q}, 0);
    chk("R1 ctl", {res_we_q, hi_we_q, valid_q}, 0);
    rst = 1'b0;
    // R3 nibble carry and carry/zero edges
    run(0, 8'h0F, 8'h01, 0, 0, 0);
    run(0, 8'hFF, 8'h01, 0, 0, 0);
    run(1, 8'h7F, 8'h80, 1, 0, 0);
    // R4 subtraction edges
    run(2, 8'h42, 8'h42, 0, 0, 0);
    run(2, 8'h10, 8'h11, 1, 1, 1);
    run(3, 8'h20, 8'h10, 0, 0, 0);
    run(3, 8'h00, 8'h00, 0, 1, 0);
    // R5 compare
    run(4, 8'h05, 8'h09, 1, 1, 1);
    // R6 increment wrap, decrement to zero
    run(9, 8'hFF, 8'h00, 1, 1, 0);
    run(10, 8'h01, 8'h00, 0, 0, 0);
    // R7 rotates through carry
    run(11, 8'h80, 8'h00, 1, 0, 1);
    run(12, 8'h01, 8'h00, 1, 1, 0);
    // R8 swap
    run(13, 8'hA5, 8'h00, 1, 0, 1);
    // R9 multiply sign corners
    run(15, 8'h80, 8'h80, 0, 0, 0);
    run(15, 8'hFF, 8'h02, 1, 1, 1);
    run(14, 8'hFF, 8'hFF, 0, 1, 0);
    run(15, 8'hFF, 8'hFF, 0, 1, 0);
    // R2: idle cycle holds outputs
    held = res_q;
    @(negedge clk);
    a_in = 8'h3C; op = 4'd8;
    @(negedge clk);
    chk("R2 idle valid", valid_q, 0);
    chk("R2 idle hold", res_q, held);
    // random traffic
    for (int i = 0; i < 600; i++) begin
      run($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255),
          $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule